// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This unit sits beside a small processor core and decides which of five hardware interrupt requests, if any, the core takes. One request is non-maskable. One is edge-sensitive and held in a latch. Two are level-sensitive and can be masked one by one. The last is a general-purpose level request from an external device. A global enable gates everything except the non-maskable input. The core pulses `sample_stb` at the one point in each instruction where requests may be taken. The unit then answers with a one-clock `accept` pulse and the index of the chosen source.

Accepting any source clears the global enable, and the core must send an enable command to turn it back on. While the bus is held by another master, no source is recognized, the non-maskable one included. When the external general-purpose request is taken, the requesting device receives an acknowledge pulse of configurable length.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset, `accept`, `ext_ack` and `glb_en` are 0, all three mask bits are clear and the edge latch is empty. Maskable requests are therefore not accepted until an enable command arrives.
- R2: When several sources are eligible at a strobe, the lowest index wins. Indices are 0 for the non-maskable input, 1 for the edge input, 2 for the mid input, 3 for the low input and 4 for the external input.
- R3: The non-maskable input is accepted at a strobe whether `glb_en` is 0 or 1 and whatever the mask bits hold, including straight after reset.
- R4: Requests are evaluated only in a cycle where `sample_stb` is 1. Requests held without a strobe never raise `accept`.
- R5: In a cycle with `hold_active` at 1, a strobe accepts nothing, even with the non-maskable input high.
- R6: A strobe that finds an eligible source raises `accept` for exactly one clock, starting in the cycle after the strobe edge. In that cycle `accept_idx` carries the source index.
- R7: Every acceptance clears `glb_en`. `cmd_en` sets it and `cmd_dis` clears it. When both commands arrive together, disable wins. An acceptance in the same cycle as `cmd_en` leaves `glb_en` at 0.
- R8: `mask_bits` bit 0 masks the edge input, bit 1 the mid input and bit 2 the low input, where 1 means masked. The external input ignores the mask bits and follows only `glb_en`.
- R9: The edge latch is set by a 0-to-1 change on `req_fast`, whether or not that input is masked. A request held high does not set it again. The latch is cleared when source 1 is accepted, or by a mask write with `mask_clr_fast` at 1. A new edge in the same cycle as such a clear wins.
- R10: When source 4 is accepted, `ext_ack` is high for exactly ACK_LEN cycles, starting in the cycle in which `accept` is high. It never rises for any other source.
- R11: The mask bits change only on a cycle with `mask_wr` at 1, and then take the value of `mask_bits`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_nmi | input | 1 | Non-maskable level request (source 0) |
| req_fast | input | 1 | Edge-latched request (source 1) |
| req_mid | input | 1 | Maskable level request (source 2) |
| req_low | input | 1 | Maskable level request (source 3) |
| req_ext | input | 1 | External general-purpose level request (source 4) |
| sample_stb | input | 1 | Instruction-boundary sampling strobe from the core |
| hold_active | input | 1 | Bus hold in effect; blocks all recognition |
| cmd_en | input | 1 | Enable command for the maskable system |
| cmd_dis | input | 1 | Disable command for the maskable system |
| mask_wr | input | 1 | Mask register write strobe |
| mask_bits | input | 3 | Mask values for sources 1..3 (1 = masked) |
| mask_clr_fast | input | 1 | With `mask_wr`, clears the edge latch |
| accept | output | 1 | One-clock acceptance pulse |
| accept_idx | output | 3 | Index of the accepted source |
| ext_ack | output | 1 | Acknowledge pulse to the external requester |
| glb_en | output | 1 | Current state of the global enable |

## Verification
The bench builds the unit with ACK_LEN set to 3 rather than the default of 1. A stretched acknowledge can then be followed cycle by cycle, which shows that it starts together with `accept` and drops after exactly three clocks. With a one-cycle pulse, an off-by-one in the counter and a late start would look identical. The remaining behaviour does not depend on parameters, so the same build also covers the priority order, the interplay of hold with the non-maskable input, and the latch's set-over-clear rule.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int NUM_SRC = 5;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int MASK_W  = 3;

  typedef logic [IDX_W-1:0] src_idx_t;

  localparam src_idx_t SRC_NMI  = 3'd0;
  localparam src_idx_t SRC_FAST = 3'd1;
  localparam src_idx_t SRC_MID  = 3'd2;
  localparam src_idx_t SRC_LOW  = 3'd3;
  localparam src_idx_t SRC_EXT  = 3'd4;

  // Lowest set index of the candidate vector (highest priority first).
  function automatic src_idx_t first_set(input logic [NUM_SRC-1:0] cand);
    src_idx_t r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i]) r = src_idx_t'(i);
    end
    return r;
  endfunction

  // Which sources may be taken, given enable and mask state.
  function automatic logic [NUM_SRC-1:0] eligible(
    input logic              nmi,
    input logic              fast_pend,
    input logic              mid,
    input logic              low,
    input logic              ext,
    input logic              en,
    input logic [MASK_W-1:0] mask
  );
    logic [NUM_SRC-1:0] c;
    c[0] = nmi;
    c[1] = en & fast_pend & ~mask[0];
    c[2] = en & mid       & ~mask[1];
    c[3] = en & low       & ~mask[2];
    c[4] = en & ext;
    return c;
  endfunction
endpackage

// File: rtl/irq_rise_latch.sv
module irq_rise_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic clr,
  output logic pend
);
  logic req_prev;
  logic rise;

  assign rise = req & ~req_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_prev <= 1'b0;
      pend     <= 1'b0;
    end else begin
      req_prev <= req;
      if (rise)     pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl
  import irq_accept_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_en,
  input  logic              cmd_dis,
  input  logic              mask_wr,
  input  logic [MASK_W-1:0] mask_bits,
  input  logic              fire,
  output logic              glb_en,
  output logic [MASK_W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_en <= 1'b0;
      mask_q <= '0;
    end else begin
      if (fire)         glb_en <= 1'b0;
      else if (cmd_dis) glb_en <= 1'b0;
      else if (cmd_en)  glb_en <= 1'b1;
      if (mask_wr) mask_q <= mask_bits;
    end
  end
endmodule

// File: rtl/irq_ack_timer.sv
module irq_ack_timer #(
  parameter int ACK_LEN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(ACK_LEN + 1);

  generate
    if (ACK_LEN == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) busy <= 1'b0;
        else        busy <= start;
      end
    end else begin : g_count
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CNT_W'(ACK_LEN);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
      end
      assign busy = (cnt != '0);
    end
  endgenerate
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter int ACK_LEN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_nmi,
  input  logic              req_fast,
  input  logic              req_mid,
  input  logic              req_low,
  input  logic              req_ext,
  input  logic              sample_stb,
  input  logic              hold_active,
  input  logic              cmd_en,
  input  logic              cmd_dis,
  input  logic              mask_wr,
  input  logic [MASK_W-1:0] mask_bits,
  input  logic              mask_clr_fast,
  output logic              accept,
  output logic [IDX_W-1:0]  accept_idx,
  output logic              ext_ack,
  output logic              glb_en
);
  logic               fast_pend;
  logic               fast_clr;
  logic [MASK_W-1:0]  mask_q;
  logic [NUM_SRC-1:0] cand;
  src_idx_t           pick;
  logic               fire;
  logic               fire_ext;

  assign cand     = eligible(req_nmi, fast_pend, req_mid, req_low, req_ext, glb_en, mask_q);
  assign pick     = first_set(cand);
  assign fire     = sample_stb & ~hold_active & (|cand);
  assign fire_ext = fire & (pick == SRC_EXT);
  assign fast_clr = (fire & (pick == SRC_FAST)) | (mask_wr & mask_clr_fast);

  irq_rise_latch u_fast (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_fast),
    .clr   (fast_clr),
    .pend  (fast_pend)
  );

  irq_enable_ctrl u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_en    (cmd_en),
    .cmd_dis   (cmd_dis),
    .mask_wr   (mask_wr),
    .mask_bits (mask_bits),
    .fire      (fire),
    .glb_en    (glb_en),
    .mask_q    (mask_q)
  );

  irq_ack_timer #(.ACK_LEN(ACK_LEN)) u_ack (
    .clk   (clk),
    .rst_n (rst_n),
    .start (fire_ext),
    .busy  (ext_ack)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept     <= 1'b0;
      accept_idx <= '0;
    end else begin
      accept <= fire;
      if (fire) accept_idx <= pick;
    end
  end
endmodule

// File: rtl/irq_accept_checker.sv
module irq_accept_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sample_stb,
  input logic       hold_active,
  input logic       req_nmi,
  input logic       req_fast,
  input logic       accept,
  input logic [2:0] accept_idx,
  input logic       ext_ack,
  input logic       glb_en,
  input logic       fast_pend
);
  assert_strobe_needed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(sample_stb));

  assert_hold_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !$past(hold_active));

  assert_nmi_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && req_nmi && !hold_active) |=> (accept && accept_idx == 3'd0));

  assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (accept_idx <= 3'd4));

  assert_en_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !glb_en);

  assert_ack_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_ack) |-> (accept && accept_idx == 3'd4));

  assert_fast_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fast && !$past(req_fast)) |=> fast_pend);
endmodule

bind irq_accept_unit irq_accept_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_stb  (sample_stb),
  .hold_active (hold_active),
  .req_nmi     (req_nmi),
  .req_fast    (req_fast),
  .accept      (accept),
  .accept_idx  (accept_idx),
  .ext_ack     (ext_ack),
  .glb_en      (glb_en),
  .fast_pend   (fast_pend)
);

// File: tb/irq_accept_unit_bench.sv
`timescale 1ns/1ps
module irq_accept_unit_bench;
  localparam int ACK_LEN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_nmi = 0, req_fast = 0, req_mid = 0, req_low = 0, req_ext = 0;
  logic sample_stb = 0, hold_active = 0, cmd_en = 0, cmd_dis = 0;
  logic mask_wr = 0, mask_clr_fast = 0;
  logic [2:0] mask_bits = '0;
  logic accept, ext_ack, glb_en;
  logic [2:0] accept_idx;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct { int idx; string tag; } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  irq_accept_unit #(.ACK_LEN(ACK_LEN)) u_irq_accept_unit (
    .clk(clk), .rst_n(rst_n),
    .req_nmi(req_nmi), .req_fast(req_fast), .req_mid(req_mid),
    .req_low(req_low), .req_ext(req_ext),
    .sample_stb(sample_stb), .hold_active(hold_active),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis),
    .mask_wr(mask_wr), .mask_bits(mask_bits), .mask_clr_fast(mask_clr_fast),
    .accept(accept), .accept_idx(accept_idx), .ext_ack(ext_ack), .glb_en(glb_en)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: every accept pulse must match the head of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && accept) begin
      n_chk++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected accept: actual idx %0d expected none", accept_idx);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (int'(accept_idx) != e.idx) begin
          n_fail++;
          $display("FAIL %s: actual idx %0d expected %0d", e.tag, accept_idx, e.idx);
        end
      end
    end
  end

  // Driver: one strobe cycle; exp_idx < 0 means no acceptance expected.
  task automatic strobe(input int exp_idx, input string tag);
    if (exp_idx >= 0) sb_q.push_back('{exp_idx, tag});
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    #1;
    if (exp_idx < 0) chk(accept == 1'b0, tag, accept, 0);
    else begin
      chk(sb_q.size() == 0, tag, 0, exp_idx);
      sb_q.delete();
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enable();
    cmd_en = 1'b1; @(negedge clk); cmd_en = 1'b0;
  endtask

  task automatic write_mask(input logic [2:0] b, input logic clr);
    mask_wr = 1'b1; mask_bits = b; mask_clr_fast = clr;
    @(negedge clk);
    mask_wr = 1'b0; mask_clr_fast = 1'b0;
  endtask

  task automatic fast_pulse();
    req_fast = 1'b1; @(negedge clk); req_fast = 1'b0; @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    #1;
    chk(accept == 0,  "R1 accept", accept, 0);
    chk(ext_ack == 0, "R1 ext_ack", ext_ack, 0);
    chk(glb_en == 0,  "R1 glb_en", glb_en, 0);
    @(negedge clk);
    req_mid = 1; req_low = 1; req_ext = 1;
    strobe(-1, "R1 disabled after reset");

    req_nmi = 1;
    strobe(0, "R3 nmi while disabled");
    chk(glb_en == 0, "R3 glb_en", glb_en, 0);
    cyc(1); #1;
    chk(accept == 0, "R6 single-cycle pulse", accept, 0);
    @(negedge clk);
    cyc(3); #1;
    chk(accept == 0, "R4 no strobe", accept, 0);
    @(negedge clk);

    hold_active = 1;
    strobe(-1, "R5 hold blocks nmi");
    hold_active = 0;
    strobe(0, "R5 after hold");

    enable(); #1;
    chk(glb_en == 1, "R7 enable cmd", glb_en, 1);
    @(negedge clk);
    strobe(0, "R2 nmi highest");
    chk(glb_en == 0, "R7 cleared by accept", glb_en, 0);
    @(negedge clk);
    req_nmi = 0;
    strobe(-1, "R7 stays disabled");

    enable(); strobe(2, "R2 mid over low/ext");
    req_mid = 0;
    enable(); strobe(3, "R2 low over ext");
    chk(ext_ack == 0, "R10 no ack for src3", ext_ack, 0);
    @(negedge clk);
    req_low = 0;
    enable(); strobe(4, "R10 ext accepted");
    chk(ext_ack == 1, "R10 ack cycle 1", ext_ack, 1);
    @(negedge clk); #1;
    chk(ext_ack == 1, "R10 ack cycle 2", ext_ack, 1);
    @(negedge clk); #1;
    chk(ext_ack == 1, "R10 ack cycle 3", ext_ack, 1);
    @(negedge clk); #1;
    chk(ext_ack == 0, "R10 ack ends", ext_ack, 0);
    @(negedge clk);

    cmd_en = 1; cmd_dis = 1; @(negedge clk); cmd_en = 0; cmd_dis = 0; #1;
    chk(glb_en == 0, "R7 disable wins", glb_en, 0);
    @(negedge clk);
    strobe(-1, "R7 ext blocked");
    req_ext = 0; req_nmi = 1; cmd_en = 1;
    strobe(0, "R7 accept with enable");
    cmd_en = 0;
    @(negedge clk); #1;
    chk(glb_en == 0, "R7 accept beats enable", glb_en, 0);
    @(negedge clk);
    req_nmi = 0;
    enable(); cmd_dis = 1; @(negedge clk); cmd_dis = 0; #1;
    chk(glb_en == 0, "R7 disable cmd", glb_en, 0);
    @(negedge clk);

    enable(); write_mask(3'b011, 0);
    req_mid = 1; req_low = 1;
    strobe(3, "R8 mid masked");
    enable(); write_mask(3'b111, 0);
    strobe(-1, "R8 all masked");
    req_ext = 1;
    strobe(4, "R8 ext unmaskable");
    req_ext = 0;
    cyc(3);
    enable();
    strobe(-1, "R11 mask kept");
    write_mask(3'b000, 0);
    strobe(2, "R11 mask rewritten");
    req_mid = 0; req_low = 0;

    enable(); fast_pulse();
    strobe(1, "R9 latched edge");
    enable(); req_fast = 1; @(negedge clk);
    strobe(1, "R9 edge while high");
    enable();
    strobe(-1, "R9 held level no retrigger");
    req_fast = 0;
    write_mask(3'b001, 0); fast_pulse();
    strobe(-1, "R9 masked edge");
    write_mask(3'b000, 0);
    strobe(1, "R9 masked edge kept");
    enable(); fast_pulse(); write_mask(3'b000, 1);
    strobe(-1, "R9 cleared by write");
    req_fast = 1; mask_wr = 1; mask_clr_fast = 1;
    @(negedge clk);
    req_fast = 0; mask_wr = 0; mask_clr_fast = 0;
    strobe(1, "R9 edge beats clear");

    cyc(2);
    summary();
  end
endmodule